// File: doc/BRIEF.md
# External Interrupt Priority Controller

This block gathers one non-maskable interrupt pin and three maskable request pins for a small processor core. Every pin first passes through a two-stage synchronizer. Each maskable line is then treated either as a level request or as an edge event of a chosen polarity. Edge events set a sticky pending flag. This happens even when the line is disabled or the core's global mask bit is set, so an event that occurs while the line cannot be served is not lost.

A fixed-priority arbiter presents a single request to the core. It gives the winner's vector number and the byte address of that winner's two-byte entry in the vector table. The core supplies two qualifiers: an instruction-boundary strobe and an inhibit flag, which the core raises while it executes an instruction that writes its flag register. When the core may accept the request, the block raises a pulse that asks the core to set its global mask. The core then acknowledges, and the acknowledge clears the winner's pending flag.

A wake output tells the power-down logic that there is work to do. A small register write port configures the per-line enables, the sense modes and the NMI edge polarity.

Top module: `irqc_top`

## Requirements
- R1: After reset all enable bits are 0, every sense mode is low level, the NMI polarity bit is 0 (falling), and `int_req`, `mask_set_req` and `wake` are 0 while no NMI edge has occurred.
- R2: Sense code 00 is low-level mode. The line requests only while its synchronized pin is 0, nothing is latched, and a pin change shows at the outputs no later than the third rising clock edge.
- R3: Sense code 01 latches falling edges, and codes 10 and 11 latch rising edges. An edge of the other polarity sets nothing.
- R4: An edge event on a line sets its pending flag even while the line's enable bit is 0 or `cpu_imask` is 1. The flag is served once the line is enabled and unmasked.
- R5: The NMI pending flag is set by a falling edge when the polarity bit is 0 and by a rising edge when it is 1. It raises `int_req` regardless of `cpu_imask` and of the enable bits.
- R6: Priority is fixed: NMI first, then line 0, then line 1, then line 2.
- R7: `mask_set_req` is 1 only in a cycle where `int_req`, `insn_boundary` are 1 and `flag_write_insn` is 0.
- R8: A one-cycle `ack` clears only the pending flag of the current winner (NMI or an edge-mode line). Other pending flags remain, and level requests are unaffected.
- R9: The NMI gives vector 3 at address 0x0006. Line i gives vector 4+i at address 2·(4+i). `vec_num` and `vec_addr` are 0 when `int_req` is 0.
- R10: `wake` is 1 whenever the NMI is pending or any enabled line has a pending or active request, whatever `cpu_imask` is.
- R11: Register writes (`reg_we`=1): address 0 loads the enables from data bits [2:0], address 1 loads sense modes (line i in bits [2i+1:2i]), and address 2 loads the NMI polarity from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_pin | input | 1 | Non-maskable interrupt pin (asynchronous) |
| irq_pin | input | 3 | Maskable request pins (asynchronous) |
| cpu_imask | input | 1 | Global mask bit from the core, 1 = masked |
| insn_boundary | input | 1 | Current instruction completes this cycle |
| flag_write_insn | input | 1 | Current instruction writes the flag register; defers acceptance |
| ack | input | 1 | Core acknowledges the presented interrupt |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| int_req | output | 1 | An interrupt is ready to be taken |
| vec_num | output | 8 | Vector number of the winner |
| vec_addr | output | 16 | Vector table byte address of the winner |
| mask_set_req | output | 1 | Interrupt accepted this cycle; the core must set its global mask |
| wake | output | 1 | Wake-up request to the standby logic |

## Verification
The bound checker tests several properties on every cycle:
- that `mask_set_req` never appears without a request at an uninhibited boundary;
- that a request under `cpu_imask` can only be the NMI;
- that the vector address is always twice the vector number;
- that a presented NMI persists until acknowledged;
- that `wake` covers every request.

Some properties need chosen pin histories, so only the bench scenarios can show them. These are edge polarity per sense code, latching while disabled or masked, the absence of latching in level mode, acknowledge clearing only the winner, and the arbitration order across all combinations of active lines.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    SNS_LOW  = 2'b00,
    SNS_FALL = 2'b01,
    SNS_RISE = 2'b10,
    SNS_RSV  = 2'b11
  } sense_e;

  localparam logic [1:0] RA_ENABLE = 2'd0;
  localparam logic [1:0] RA_SENSE  = 2'd1;
  localparam logic [1:0] RA_NMIPOL = 2'd2;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st1_q, st2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_q <= RST_VAL;
      st2_q <= RST_VAL;
    end else begin
      st1_q <= d;
      st2_q <= st1_q;
    end
  end

  assign q = st2_q;
endmodule

// File: rtl/irqc_line.sv
module irqc_line (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic level_mode,
  input  logic rise_sel,
  input  logic clr,
  output logic pend,
  output logic req
);
  logic prev_q;
  logic pend_q, pend_d, pend_en;
  logic rise, fall, evt;

  assign rise = pin_s & ~prev_q;
  assign fall = ~pin_s & prev_q;
  assign evt  = ~level_mode & (rise_sel ? rise : fall);

  always_comb begin
    pend_en = evt | clr;
    pend_d  = evt | (pend_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= pin_s;
      if (pend_en) pend_q <= pend_d;
    end
  end

  assign pend = pend_q;
  assign req  = level_mode ? ~pin_s : pend_q;
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs #(
  parameter int NUM_IRQ = 3,
  parameter int DATA_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [1:0]           addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [NUM_IRQ-1:0]   en,
  output logic [2*NUM_IRQ-1:0] sense,
  output logic                 nmi_rise
);
  import irqc_pkg::*;

  logic [NUM_IRQ-1:0]   en_q, en_d;
  logic [2*NUM_IRQ-1:0] sns_q, sns_d;
  logic                 pol_q, pol_d;
  logic                 en_we, sns_we, pol_we;

  always_comb begin
    en_we  = we && (addr == RA_ENABLE);
    sns_we = we && (addr == RA_SENSE);
    pol_we = we && (addr == RA_NMIPOL);
    en_d   = wdata[NUM_IRQ-1:0];
    sns_d  = wdata[2*NUM_IRQ-1:0];
    pol_d  = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      sns_q <= '0;
      pol_q <= 1'b0;
    end else begin
      if (en_we)  en_q  <= en_d;
      if (sns_we) sns_q <= sns_d;
      if (pol_we) pol_q <= pol_d;
    end
  end

  assign en       = en_q;
  assign sense    = sns_q;
  assign nmi_rise = pol_q;
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb #(
  parameter int NUM_IRQ      = 3,
  parameter int VEC_W        = 8,
  parameter int ADDR_W       = 16,
  parameter int NMI_VEC      = 3,
  parameter int IRQ_VEC_BASE = 4,
  parameter int ENTRY_BYTES  = 2
) (
  input  logic               nmi_req,
  input  logic [NUM_IRQ-1:0] irq_req,
  output logic               valid,
  output logic               win_nmi,
  output logic [NUM_IRQ-1:0] win_oh,
  output logic [VEC_W-1:0]   vec,
  output logic [ADDR_W-1:0]  vaddr
);
  always_comb begin
    valid   = nmi_req;
    win_nmi = nmi_req;
    win_oh  = '0;
    vec     = VEC_W'(NMI_VEC);
    if (!nmi_req) begin
      for (int i = NUM_IRQ - 1; i >= 0; i--) begin
        if (irq_req[i]) begin
          win_oh    = '0;
          win_oh[i] = 1'b1;
          vec       = VEC_W'(IRQ_VEC_BASE + i);
          valid     = 1'b1;
        end
      end
    end
    if (!valid) vec = '0;
    vaddr = ADDR_W'(int'(vec) * ENTRY_BYTES);
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int NUM_IRQ      = 3,
  parameter int DATA_W       = 8,
  parameter int VEC_W        = 8,
  parameter int ADDR_W       = 16,
  parameter int NMI_VEC      = 3,
  parameter int IRQ_VEC_BASE = 4,
  parameter int ENTRY_BYTES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               nmi_pin,
  input  logic [NUM_IRQ-1:0] irq_pin,
  input  logic               cpu_imask,
  input  logic               insn_boundary,
  input  logic               flag_write_insn,
  input  logic               ack,
  input  logic               reg_we,
  input  logic [1:0]         reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic               int_req,
  output logic [VEC_W-1:0]   vec_num,
  output logic [ADDR_W-1:0]  vec_addr,
  output logic               mask_set_req,
  output logic               wake
);
  import irqc_pkg::*;

  localparam int NPIN = NUM_IRQ + 1;

  logic [NPIN-1:0]      pins_raw, pins_s;
  logic [NUM_IRQ-1:0]   en;
  logic [2*NUM_IRQ-1:0] sense;
  logic                 nmi_rise;
  logic [NUM_IRQ-1:0]   line_req, line_pend, line_lvl, line_clr, eligible;
  logic                 nmi_pend, nmi_clr;
  logic                 win_nmi;
  logic [NUM_IRQ-1:0]   win_oh;

  assign pins_raw = {nmi_pin, irq_pin};

  irqc_sync #(.W(NPIN), .RST_VAL({NPIN{1'b1}})) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
  );

  irqc_regs #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .en(en), .sense(sense), .nmi_rise(nmi_rise)
  );

  generate
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
      sense_e mode;
      assign mode        = sense_e'(sense[2*g +: 2]);
      assign line_lvl[g] = (mode == SNS_LOW);
      assign line_clr[g] = ack & ~win_nmi & win_oh[g] & ~line_lvl[g];

      irqc_line u_line (
        .clk(clk), .rst_n(rst_n), .pin_s(pins_s[g]),
        .level_mode(line_lvl[g]), .rise_sel(mode != SNS_FALL),
        .clr(line_clr[g]), .pend(line_pend[g]), .req(line_req[g])
      );
    end
  endgenerate

  assign nmi_clr = ack & win_nmi;

  irqc_line u_nmi (
    .clk(clk), .rst_n(rst_n), .pin_s(pins_s[NUM_IRQ]),
    .level_mode(1'b0), .rise_sel(nmi_rise),
    .clr(nmi_clr), .pend(nmi_pend), .req()
  );

  assign eligible = line_req & en & {NUM_IRQ{~cpu_imask}};

  irqc_arb #(
    .NUM_IRQ(NUM_IRQ), .VEC_W(VEC_W), .ADDR_W(ADDR_W), .NMI_VEC(NMI_VEC),
    .IRQ_VEC_BASE(IRQ_VEC_BASE), .ENTRY_BYTES(ENTRY_BYTES)
  ) u_arb (
    .nmi_req(nmi_pend), .irq_req(eligible), .valid(int_req),
    .win_nmi(win_nmi), .win_oh(win_oh), .vec(vec_num), .vaddr(vec_addr)
  );

  assign mask_set_req = int_req & insn_boundary & ~flag_write_insn;
  assign wake         = nmi_pend | (|(line_req & en));
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int NUM_IRQ      = 3,
  parameter int DATA_W       = 8,
  parameter int VEC_W        = 8,
  parameter int ADDR_W       = 16,
  parameter int NMI_VEC      = 3,
  parameter int IRQ_VEC_BASE = 4,
  parameter int ENTRY_BYTES  = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_imask,
  input logic               insn_boundary,
  input logic               flag_write_insn,
  input logic               ack,
  input logic               int_req,
  input logic [VEC_W-1:0]   vec_num,
  input logic [ADDR_W-1:0]  vec_addr,
  input logic               mask_set_req,
  input logic               wake
);
  AST_ACCEPT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    mask_set_req |-> (int_req && insn_boundary && !flag_write_insn)); // R7

  AST_MASKED_ONLY_NMI: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && cpu_imask) |-> (vec_num == VEC_W'(NMI_VEC))); // R5

  AST_VEC_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    vec_addr == ADDR_W'(int'(vec_num) * ENTRY_BYTES)); // R9

  AST_IDLE_VEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !int_req |-> (vec_num == '0)); // R9

  AST_NMI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && vec_num == VEC_W'(NMI_VEC) && !ack) |=>
      (int_req && vec_num == VEC_W'(NMI_VEC))); // R6

  AST_WAKE_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> wake); // R10
endmodule

bind irqc_top irqc_chk #(
  .NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W), .VEC_W(VEC_W), .ADDR_W(ADDR_W),
  .NMI_VEC(NMI_VEC), .IRQ_VEC_BASE(IRQ_VEC_BASE), .ENTRY_BYTES(ENTRY_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_imask(cpu_imask),
  .insn_boundary(insn_boundary), .flag_write_insn(flag_write_insn),
  .ack(ack), .int_req(int_req), .vec_num(vec_num), .vec_addr(vec_addr),
  .mask_set_req(mask_set_req), .wake(wake)
);

// File: tb/sim_irqc_top.sv
module sim_irqc_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi_pin = 1'b1;
  logic [2:0]  irq_pin = 3'b111;
  logic        cpu_imask = 1'b0;
  logic        insn_boundary = 1'b0;
  logic        flag_write_insn = 1'b0;
  logic        ack = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        int_req, mask_set_req, wake;
  logic [7:0]  vec_num;
  logic [15:0] vec_addr;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irqc_top u0 (
    .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .irq_pin(irq_pin),
    .cpu_imask(cpu_imask), .insn_boundary(insn_boundary),
    .flag_write_insn(flag_write_insn), .ack(ack), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .int_req(int_req),
    .vec_num(vec_num), .vec_addr(vec_addr), .mask_set_req(mask_set_req),
    .wake(wake)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_we = 1'b0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    step(1);
    ack = 1'b0;
    step(1);
  endtask

  task automatic chk_vec(input string req, input int exp_vec);
    chk(req, int'(int_req), exp_vec != 0 ? 1 : 0);
    chk(req, int'(vec_num), exp_vec);
    chk(req, int'(vec_addr), exp_vec * 2);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(4);
    // R1: reset state
    chk("R1", int'(int_req), 0);
    chk("R1", int'(wake), 0);
    chk("R1", int'(mask_set_req), 0);
    irq_pin = 3'b000;
    step(4);
    chk("R1 enables off", int'(wake), 0);
    irq_pin = 3'b111;
    step(4);

    // R11, R2, R6, R9, R10: level sweep over all pin patterns
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h07);
    for (int m = 0; m < 2; m++) begin
      cpu_imask = m[0];
      for (int p = 0; p < 8; p++) begin
        int ev;
        irq_pin = ~p[2:0];
        step(4);
        ev = 0;
        for (int j = 2; j >= 0; j--) if (p[j]) ev = 4 + j;
        if (m == 1) ev = 0;
        chk_vec("R2/R6/R9", ev);
        chk("R10", int'(wake), p != 0 ? 1 : 0);
      end
      irq_pin = 3'b111;
      step(4);
      chk("R2 not latched", int'(int_req), 0);
    end
    cpu_imask = 1'b0;

    // R3, R8: edge modes per line
    for (int i = 0; i < 3; i++) begin
      wr(2'd0, 8'(1 << i));
      for (int md = 1; md < 4; md++) begin
        wr(2'd1, 8'(md << (2 * i)));
        irq_pin[i] = 1'b0;
        step(4);
        chk("R3 first edge", int'(int_req), md == 1 ? 1 : 0);
        irq_pin[i] = 1'b1;
        step(4);
        chk_vec("R3 latched", 4 + i);
        pulse_ack();
        chk("R8 cleared", int'(int_req), 0);
      end
    end

    // R4: latch while disabled and masked
    wr(2'd1, 8'(2 << 2));
    wr(2'd0, 8'h00);
    cpu_imask = 1'b1;
    irq_pin[1] = 1'b0; step(4);
    irq_pin[1] = 1'b1; step(4);
    chk("R4 disabled", int'(int_req), 0);
    chk("R4 disabled wake", int'(wake), 0);
    wr(2'd0, 8'h02);
    step(1);
    chk("R4 masked", int'(int_req), 0);
    chk("R4 wake", int'(wake), 1);
    cpu_imask = 1'b0;
    step(1);
    chk_vec("R4 served", 5);
    pulse_ack();

    // R5: NMI falling (default), then rising, ignores mask
    cpu_imask = 1'b1;
    nmi_pin = 1'b0; step(4);
    chk_vec("R5 falling", 3);
    pulse_ack();
    chk("R5 cleared", int'(int_req), 0);
    wr(2'd2, 8'h01);
    nmi_pin = 1'b1; step(4);
    chk_vec("R5 rising", 3);
    pulse_ack();
    nmi_pin = 1'b0; step(4);
    chk("R5 wrong edge", int'(int_req), 0);

    // R6: NMI over level line 0
    cpu_imask = 1'b0;
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h01);
    irq_pin[0] = 1'b0;
    nmi_pin = 1'b1; step(4);
    chk_vec("R6 nmi first", 3);
    pulse_ack();
    chk_vec("R6 then line0", 4);

    // R7: acceptance gating
    insn_boundary = 1'b0; #1;
    chk("R7 no boundary", int'(mask_set_req), 0);
    insn_boundary = 1'b1; flag_write_insn = 1'b1; #1;
    chk("R7 inhibit", int'(mask_set_req), 0);
    flag_write_insn = 1'b0; #1;
    chk("R7 accept", int'(mask_set_req), 1);
    irq_pin[0] = 1'b1;
    step(4);
    chk("R7 idle", int'(mask_set_req), 0);
    insn_boundary = 1'b0;

    // R8: ack clears only the winner
    wr(2'd1, 8'h22);
    wr(2'd0, 8'h05);
    irq_pin = 3'b010; step(4);
    irq_pin = 3'b111; step(4);
    chk_vec("R8 both", 4);
    pulse_ack();
    chk_vec("R8 remains", 6);
    pulse_ack();
    chk("R8 all clear", int'(int_req), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule